// File: doc/BRIEF.md
# Processor Supervisor Reset Controller

This block is the digital core of a processor supervisor. It watches three asynchronous comparator results: a supply low-line flag, a power-fail flag that says the early-warning input is below its threshold, and the watchdog line that processor software toggles. It also takes a one-millisecond timebase pulse. From these it produces a processor reset in both polarities, a power-fail warning meant for an interrupt input, and a watchdog-timeout status flag.

Reset is held for as long as the supply is low and is then stretched for a fixed number of timebase ticks, which also gives the power-on reset and rides out a supply that bounces. If the watchdog line stays still for too long while watchdog supervision is enabled, the block issues a reset pulse of the same stretched length. The power-fail warning tracks its comparator on its own and has no effect on reset. All of these pins are plain level signals, so there is no handshake and no back-pressure at any edge of the block.

Top module: `mp_supervisor`

## Requirements
- R1: While the synchronous `rst` input is high, and on the first clock after it, `rst_out` is 1, `rst_out_n` is 0 and `wdog_tmo` is 0; after `rst` falls, with the supply good, reset releases on the STRETCH_TICKS-th tick pulse.
- R2: Once `lowline_async` has been high for three clock edges, `rst_out` is 1 and stays 1 for as long as the input stays high.
- R3: After `lowline_async` falls, reset releases on the STRETCH_TICKS-th `tick_ms` pulse counted once the synchronized low-line flag has cleared, and it never releases on a cycle without a tick.
- R4: `rst_out_n` is always the inverse of `rst_out`.
- R5: `pfail_warn` equals `pfail_async` delayed by two clock edges, whatever the reset state.
- R6: Each rising and each falling edge of `wdi_async` restarts the watchdog count, so a line that changes at least once every WDOG_TICKS-1 ticks never causes a reset.
- R7: With `wdog_en` high and reset released, WDOG_TICKS tick pulses with no watchdog edge raise `rst_out`, which then stays high for STRETCH_TICKS further ticks.
- R8: The watchdog count is cleared and held while reset is asserted, so after any release a full WDOG_TICKS ticks are needed before the next watchdog reset.
- R9: While `wdog_en` is low, the watchdog never raises reset, however long the line stays still.
- R10: `wdog_tmo` goes to 1 on the cycle a watchdog reset starts and returns to 0 on the next watchdog edge or when the low-line flag is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous system reset, active high |
| tick_ms | input | 1 | One-cycle timebase pulse, nominally once per millisecond |
| lowline_async | input | 1 | Supply below its reset threshold (asynchronous) |
| pfail_async | input | 1 | Power-fail input below its reference (asynchronous) |
| wdi_async | input | 1 | Watchdog line toggled by software (asynchronous) |
| wdog_en | input | 1 | Enables watchdog supervision |
| rst_out | output | 1 | Processor reset, active high |
| rst_out_n | output | 1 | Processor reset, active low |
| pfail_warn | output | 1 | Early power-fail warning |
| wdog_tmo | output | 1 | Watchdog-timeout status flag |

## Verification
The bench builds the block with STRETCH_TICKS at 4 and WDOG_TICKS at 10, and issues a tick every fourth clock. With those values a full watchdog timeout, the following reset pulse and a second timeout after release each take only a few dozen clocks, so timeouts, restarts by both edge directions, the disabled case and the clearing of the status flag are all reached in a short run. The exact tick counts of the release and the timeout are checked against these small parameter values, while a behavioural model follows every output on every clock.

// File: rtl/sup_pkg.sv
package sup_pkg;
  localparam int NCMP = 3;

  typedef struct packed {
    logic wd;
    logic pf;
    logic low;
  } cmp_t;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
  parameter int STRETCH_TICKS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic force_on,
  output logic active
);
  localparam int SW = $clog2(STRETCH_TICKS + 1);
  localparam logic [SW-1:0] LOAD = SW'(STRETCH_TICKS);

  logic [SW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst || force_on) begin
      active <= 1'b1;
      remain <= LOAD;
    end else if (active && tick) begin
      if (remain <= SW'(1)) begin
        active <= 1'b0;
        remain <= '0;
      end else begin
        remain <= remain - SW'(1);
      end
    end
  end
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int WDOG_TICKS = 1600
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tick,
  input  logic                          en,
  input  logic                          hold,
  input  logic                          line_s,
  output logic                          fire,
  output logic                          kick,
  output logic [$clog2(WDOG_TICKS)-1:0] count
);
  localparam int CW = $clog2(WDOG_TICKS);
  localparam logic [CW-1:0] LAST = CW'(WDOG_TICKS - 1);

  logic line_prev;

  assign kick = line_s ^ line_prev;
  assign fire = en && !hold && !kick && tick && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst) line_prev <= 1'b0;
    else     line_prev <= line_s;
  end

  always_ff @(posedge clk) begin
    if (rst || hold || !en || kick) count <= '0;
    else if (tick) count <= (count == LAST) ? '0 : count + CW'(1);
  end
endmodule

// File: rtl/mp_supervisor.sv
module mp_supervisor #(
  parameter int STRETCH_TICKS = 50,
  parameter int WDOG_TICKS    = 1600,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_ms,
  input  logic lowline_async,
  input  logic pfail_async,
  input  logic wdi_async,
  input  logic wdog_en,
  output logic rst_out,
  output logic rst_out_n,
  output logic pfail_warn,
  output logic wdog_tmo
);
  import sup_pkg::*;
  localparam int CW = $clog2(WDOG_TICKS);

  cmp_t          raw_in, syn_in;
  logic          low_s, wd_fire, wd_kick, rst_act;
  logic [CW-1:0] wd_cnt;

  assign raw_in = '{wd: wdi_async, pf: pfail_async, low: lowline_async};

  sup_sync #(.W(NCMP), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn_in)
  );

  assign low_s = syn_in.low;

  sup_wdog #(.WDOG_TICKS(WDOG_TICKS)) u_wd (
    .clk(clk), .rst(rst), .tick(tick_ms), .en(wdog_en), .hold(rst_act),
    .line_s(syn_in.wd), .fire(wd_fire), .kick(wd_kick), .count(wd_cnt)
  );

  sup_stretch #(.STRETCH_TICKS(STRETCH_TICKS)) u_str (
    .clk(clk), .rst(rst), .tick(tick_ms), .force_on(low_s | wd_fire),
    .active(rst_act)
  );

  always_ff @(posedge clk) begin
    if (rst || low_s) wdog_tmo <= 1'b0;
    else if (wd_fire) wdog_tmo <= 1'b1;
    else if (wd_kick) wdog_tmo <= 1'b0;
  end

  assign rst_out    = rst_act;
  assign rst_out_n  = ~rst_act;
  assign pfail_warn = syn_in.pf;
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
  parameter int WDOG_TICKS = 1600
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          tick_ms,
  input logic                          wdog_en,
  input logic                          rst_out,
  input logic                          wdog_tmo,
  input logic                          low_s,
  input logic                          wd_fire,
  input logic [$clog2(WDOG_TICKS)-1:0] wd_cnt
);
  a_r2_lowline_forces_reset: assert property (@(posedge clk) disable iff (rst)
    low_s |=> rst_out);

  a_r10_lowline_clears_flag: assert property (@(posedge clk) disable iff (rst)
    low_s |=> !wdog_tmo);

  a_r3_release_on_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_out) |-> ($past(tick_ms) && !$past(low_s)));

  a_r7_timeout_resets: assert property (@(posedge clk) disable iff (rst)
    wd_fire |=> (rst_out && wdog_tmo));

  a_r8_count_held: assert property (@(posedge clk) disable iff (rst)
    rst_out |=> (wd_cnt == '0));

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !wdog_en |-> !wd_fire);
endmodule

bind mp_supervisor sup_checker #(.WDOG_TICKS(WDOG_TICKS)) u_chk (
  .clk(clk), .rst(rst), .tick_ms(tick_ms), .wdog_en(wdog_en),
  .rst_out(rst_out), .wdog_tmo(wdog_tmo), .low_s(low_s),
  .wd_fire(wd_fire), .wd_cnt(wd_cnt)
);

// File: tb/sim_mp_supervisor.sv
`timescale 1ns/1ps
module sim_mp_supervisor;
  localparam int S = 4;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_ms = 1'b0;
  logic lowline_async = 1'b0, pfail_async = 1'b0, wdi_async = 1'b0, wdog_en = 1'b0;
  logic rst_out, rst_out_n, pfail_warn, wdog_tmo;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mp_supervisor #(.STRETCH_TICKS(S), .WDOG_TICKS(W)) u0 (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .lowline_async(lowline_async),
    .pfail_async(pfail_async), .wdi_async(wdi_async), .wdog_en(wdog_en),
    .rst_out(rst_out), .rst_out_n(rst_out_n), .pfail_warn(pfail_warn),
    .wdog_tmo(wdog_tmo)
  );

  // timebase: one tick every fourth clock, changed on the falling edge
  int tphase = 0;
  always @(negedge clk) begin
    tphase  <= (tphase + 1) % 4;
    tick_ms <= (tphase == 3);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference, evaluated at each rising edge
  int m_low[2], m_pf[2], m_wd[2];
  int m_prev = 0, m_act = 1, m_left = S, m_cnt = 0, m_tmo = 0;
  always @(posedge clk) begin
    int kick, fire, n_act, n_left, n_cnt, n_tmo;
    if (rst) begin
      m_low = '{0, 0}; m_pf = '{0, 0}; m_wd = '{0, 0};
      m_prev = 0; m_act = 1; m_left = S; m_cnt = 0; m_tmo = 0;
    end else begin
      kick = (m_wd[1] != m_prev);
      fire = wdog_en && !m_act && !kick && tick_ms && (m_cnt == W - 1);
      n_tmo = m_low[1] ? 0 : fire ? 1 : kick ? 0 : m_tmo;
      n_act = m_act; n_left = m_left;
      if (m_low[1] || fire) begin
        n_act = 1; n_left = S;
      end else if (m_act && tick_ms) begin
        if (m_left <= 1) begin n_act = 0; n_left = 0; end
        else n_left = m_left - 1;
      end
      if (m_act || !wdog_en || kick) n_cnt = 0;
      else if (tick_ms) n_cnt = (m_cnt == W - 1) ? 0 : m_cnt + 1;
      else n_cnt = m_cnt;
      m_prev = m_wd[1];
      m_low[1] = m_low[0]; m_low[0] = lowline_async;
      m_pf[1]  = m_pf[0];  m_pf[0]  = pfail_async;
      m_wd[1]  = m_wd[0];  m_wd[0]  = wdi_async;
      m_act = n_act; m_left = n_left; m_cnt = n_cnt; m_tmo = n_tmo;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      chk(rst_out === m_act[0], "R2 model rst_out", rst_out, m_act);
      chk(rst_out_n === !m_act[0], "R4 model rst_out_n", rst_out_n, !m_act[0]);
      chk(pfail_warn === m_pf[1][0], "R5 model pfail_warn", pfail_warn, m_pf[1]);
      chk(wdog_tmo === m_tmo[0], "R10 model wdog_tmo", wdog_tmo, m_tmo);
    end
  end

  task automatic edge1;
    @(posedge clk); #1;
  endtask

  task automatic wait_tick_edge;
    do edge1(); while (!tick_ms);
  endtask

  // counts tick pulses consumed until rst_out reaches the given level
  task automatic ticks_until(input logic lvl, output int n);
    n = 0;
    for (int i = 0; i < 4000; i++) begin
      edge1();
      if (tick_ms) n++;
      if (rst_out === lvl) break;
    end
  endtask

  initial begin
    int n;
    bit saw;
    repeat (3) @(negedge clk);
    // R1: state while in reset
    chk(rst_out === 1'b1 && rst_out_n === 1'b0, "R1 reset level", rst_out, 1);
    chk(wdog_tmo === 1'b0 && pfail_warn === 1'b0, "R1 flags in reset", wdog_tmo, 0);
    wait_tick_edge();
    @(negedge clk); rst = 1'b0;
    edge1();
    chk(rst_out === 1'b1, "R1 first clock after reset", rst_out, 1);
    ticks_until(1'b0, n);
    chk(n == S, "R1 release ticks after reset", n, S);

    // R2: low-line asserts reset
    @(negedge clk); lowline_async = 1'b1;
    repeat (3) edge1();
    chk(rst_out === 1'b1, "R2 reset on low line", rst_out, 1);
    repeat (20) edge1();
    chk(rst_out === 1'b1, "R2 reset held while low", rst_out, 1);
    // R5 during reset
    @(negedge clk); pfail_async = 1'b1;
    repeat (2) edge1();
    chk(pfail_warn === 1'b1, "R5 warning during reset", pfail_warn, 1);
    @(negedge clk); pfail_async = 1'b0;
    // R3: stretch after recovery
    wait_tick_edge();
    @(negedge clk); lowline_async = 1'b0;
    ticks_until(1'b0, n);
    chk(n == S, "R3 stretch ticks", n, S);

    // R5 independent of reset
    @(negedge clk); pfail_async = 1'b1;
    edge1();
    chk(pfail_warn === 1'b0, "R5 one edge latency", pfail_warn, 0);
    edge1();
    chk(pfail_warn === 1'b1 && rst_out === 1'b0, "R5 warning no reset", rst_out, 0);
    @(negedge clk); pfail_async = 1'b0;

    // R9: disabled watchdog never resets
    saw = 0;
    for (int t = 0; t < 3 * W; t++) begin
      wait_tick_edge();
      if (rst_out) saw = 1;
    end
    chk(!saw, "R9 no reset while disabled", saw, 0);

    // R6: regular toggling keeps the line alive
    @(negedge clk); wdog_en = 1'b1;
    saw = 0;
    for (int k = 0; k < 8; k++) begin
      for (int t = 0; t < W / 2; t++) begin
        wait_tick_edge();
        if (rst_out) saw = 1;
      end
      @(negedge clk); wdi_async = ~wdi_async;
    end
    chk(!saw, "R6 toggling prevents reset", saw, 0);

    // R7: timeout after W quiet ticks
    wait_tick_edge();
    @(negedge clk); wdi_async = ~wdi_async;
    ticks_until(1'b1, n);
    chk(n == W, "R7 timeout ticks", n, W);
    chk(wdog_tmo === 1'b1, "R10 flag set on timeout", wdog_tmo, 1);
    ticks_until(1'b0, n);
    chk(n == S, "R7 pulse length", n, S);

    // R8: full window again after release
    ticks_until(1'b1, n);
    chk(n == W, "R8 full window after release", n, W);
    ticks_until(1'b0, n);

    // R10: edge clears flag
    @(negedge clk); wdi_async = ~wdi_async;
    repeat (3) edge1();
    chk(wdog_tmo === 1'b0, "R10 edge clears flag", wdog_tmo, 0);
    ticks_until(1'b1, n);
    chk(wdog_tmo === 1'b1, "R10 flag set again", wdog_tmo, 1);
    @(negedge clk); lowline_async = 1'b1;
    repeat (4) edge1();
    chk(wdog_tmo === 1'b0, "R10 low line clears flag", wdog_tmo, 0);
    wait_tick_edge();
    @(negedge clk); lowline_async = 1'b0;
    ticks_until(1'b0, n);
    chk(n == S, "R3 stretch after second low line", n, S);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule